// File: doc/BRIEF.md
# Timed Register Transfer Datapath

This block holds two small datapaths that move data between registers under control variables. The first has a bank of four 8-bit source registers and one 8-bit destination register. Four timing inputs, of which at most one may be high in a cycle, pick the source that is copied into the destination on the next clock edge. The timing lines are encoded into a binary multiplexer select. Their OR forms the load enable of the destination, so the destination keeps its value in any cycle where no timing line is high.

The second datapath holds a 4-bit accumulator and a 4-bit operand register. A step input makes the accumulator take a new value. A mode input chooses that value. With the mode high, the new value is the wrapped sum of the accumulator and the operand. With the mode low, it is a plain copy of the operand. The source registers and the operand register are written through simple load ports. Every register is cleared by a synchronous active-high reset.

Top module: `xfer_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the destination, accumulator, operand and all four source registers clear to 0. Afterwards `dst_q` and `acc_q` read 0, and a transfer from any source delivers 0.
- R2: When bit k of `tsel` is high (k = 0..3), `dst_q` equals the content of source register k one cycle later.
- R3: When `tsel` is all zero, `dst_q` keeps its value.
- R4: When bit k of `src_we` is high, source register k loads `src_wdata` at the edge. A source whose enable bit is low keeps its content. A transfer in the same cycle as a write to that source carries the old content.
- R5: With `step` and `mode_add` both high, `acc_q` becomes (`acc_q` + operand) mod 16 at the edge, and the carry is dropped.
- R6: With `step` high and `mode_add` low, `acc_q` becomes the operand value held before the edge.
- R7: With `step` low, `acc_q` keeps its value whatever `mode_add` is.
- R8: When `opd_we` is high, the operand register loads `opd_wdata` at the edge. A step in that same cycle uses the previous operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_we | input | 4 | Per-source write enables |
| src_wdata | input | 8 | Write data for the source registers |
| tsel | input | 4 | One-hot timing inputs selecting the source for the destination |
| dst_q | output | 8 | Destination register |
| opd_we | input | 1 | Operand register write enable |
| opd_wdata | input | 4 | Operand write data |
| step | input | 1 | Accumulator load enable |
| mode_add | input | 1 | 1: accumulate the operand, 0: copy the operand |
| acc_q | output | 4 | Accumulator register |

## Verification
A wrong select encoding shows up as `dst_q` holding a neighbouring source's value one cycle after the timing pulse. A missing load gate shows as `dst_q` changing in an idle cycle. A bad source or operand register stays hidden until it is transferred, so each write is followed by a transfer, a copy or a sum that brings its content to the ports within one or two cycles. Adder faults, including a carry that is kept instead of dropped, show in `acc_q` on the edge right after the step. Sums that pass 15 are driven on purpose so that the wrap is exposed.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int WIDE_W   = 8;
  localparam int NSRC     = 4;
  localparam int NARROW_W = 4;
endpackage

// File: rtl/xfer_source_bank.sv
module xfer_source_bank #(
  parameter int W = xfer_pkg::WIDE_W,
  parameter int N = xfer_pkg::NSRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      we,
  input  logic [W-1:0]      wdata,
  output logic [N-1:0][W-1:0] regs_q
);
  for (genvar k = 0; k < N; k++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        regs_q[k] <= '0;
      else if (we[k]) regs_q[k] <= wdata;
    end

    // R4: write takes the data, idle register keeps content
    p_src_write_r4: assert property (@(posedge clk) disable iff (rst)
      we[k] |=> regs_q[k] == $past(wdata));
    p_src_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !we[k] |=> $stable(regs_q[k]));
  end
endmodule

// File: rtl/xfer_steer.sv
module xfer_steer #(
  parameter int W = xfer_pkg::WIDE_W,
  parameter int N = xfer_pkg::NSRC,
  localparam int SEL_W = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        tsel,
  input  logic [N-1:0][W-1:0] src_q,
  output logic [W-1:0]        dst_q
);
  // one-hot to binary: bit b of the select is the OR of lines whose index has bit b set
  function automatic logic [SEL_W-1:0] encode_timing(input logic [N-1:0] t);
    logic [SEL_W-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++)
      if (t[i]) s = s | SEL_W'(i);
    return s;
  endfunction

  logic [SEL_W-1:0] sel_idx;
  logic             dst_load;
  logic [W-1:0]     mux_out;

  assign sel_idx  = encode_timing(tsel);
  assign dst_load = |tsel;
  assign mux_out  = src_q[sel_idx];

  always_ff @(posedge clk) begin
    if (rst)           dst_q <= '0;
    else if (dst_load) dst_q <= mux_out;
  end

  // R2: timing inputs are mutually exclusive
  p_onehot_timing_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tsel));
  // R3: idle timing keeps the destination
  p_dst_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !dst_load |=> $stable(dst_q));
  for (genvar k = 0; k < N; k++) begin : g_chk
    // R2: line k copies source k
    p_dst_from_src_r2: assert property (@(posedge clk) disable iff (rst)
      tsel[k] |=> dst_q == $past(src_q[k]));
  end
endmodule

// File: rtl/xfer_accum.sv
module xfer_accum #(
  parameter int W = xfer_pkg::NARROW_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         opd_we,
  input  logic [W-1:0] opd_wdata,
  input  logic         step,
  input  logic         mode_add,
  output logic [W-1:0] acc_q
);
  function automatic logic [W-1:0] add_wrap(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[W-1:0];
  endfunction

  logic [W-1:0] opd_q;
  logic [W-1:0] sum_val;
  logic [W-1:0] acc_next;

  assign sum_val  = add_wrap(acc_q, opd_q);
  assign acc_next = mode_add ? sum_val : opd_q;

  always_ff @(posedge clk) begin
    if (rst)         opd_q <= '0;
    else if (opd_we) opd_q <= opd_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (step) acc_q <= acc_next;
  end

  // R5: accumulate wraps modulo 2**W
  p_acc_add_r5: assert property (@(posedge clk) disable iff (rst)
    (step && mode_add) |=> acc_q == W'($past(acc_q) + $past(opd_q)));
  // R6: plain transfer of the operand
  p_acc_copy_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !mode_add) |=> acc_q == $past(opd_q));
  // R7: no step, no change
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(acc_q));
  // R8: operand write
  p_opd_write_r8: assert property (@(posedge clk) disable iff (rst)
    opd_we |=> opd_q == $past(opd_wdata));
endmodule

// File: rtl/xfer_datapath.sv
module xfer_datapath #(
  parameter int WIDE_W   = xfer_pkg::WIDE_W,
  parameter int NSRC     = xfer_pkg::NSRC,
  parameter int NARROW_W = xfer_pkg::NARROW_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NSRC-1:0]     src_we,
  input  logic [WIDE_W-1:0]   src_wdata,
  input  logic [NSRC-1:0]     tsel,
  output logic [WIDE_W-1:0]   dst_q,
  input  logic                opd_we,
  input  logic [NARROW_W-1:0] opd_wdata,
  input  logic                step,
  input  logic                mode_add,
  output logic [NARROW_W-1:0] acc_q
);
  logic [NSRC-1:0][WIDE_W-1:0] src_q;

  xfer_source_bank #(.W(WIDE_W), .N(NSRC)) u_bank (
    .clk(clk), .rst(rst), .we(src_we), .wdata(src_wdata), .regs_q(src_q));

  xfer_steer #(.W(WIDE_W), .N(NSRC)) u_steer (
    .clk(clk), .rst(rst), .tsel(tsel), .src_q(src_q), .dst_q(dst_q));

  xfer_accum #(.W(NARROW_W)) u_accum (
    .clk(clk), .rst(rst), .opd_we(opd_we), .opd_wdata(opd_wdata),
    .step(step), .mode_add(mode_add), .acc_q(acc_q));
endmodule

// File: tb/xfer_datapath_bench.sv
module xfer_datapath_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] src_we = '0;
  logic [7:0] src_wdata = '0;
  logic [3:0] tsel = '0;
  logic [7:0] dst_q;
  logic       opd_we = 1'b0;
  logic [3:0] opd_wdata = '0;
  logic       step = 1'b0;
  logic       mode_add = 1'b0;
  logic [3:0] acc_q;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_datapath u_xfer_datapath (
    .clk(clk), .rst(rst), .src_we(src_we), .src_wdata(src_wdata), .tsel(tsel),
    .dst_q(dst_q), .opd_we(opd_we), .opd_wdata(opd_wdata), .step(step),
    .mode_add(mode_add), .acc_q(acc_q));

  // {opd_we, opd_wdata[3:0], step, mode_add, expected acc after the edge[3:0]}
  localparam logic [10:0] VEC [12] = '{
    {1'b1, 4'h5, 1'b0, 1'b0, 4'h0},  // R8 write, R7 hold
    {1'b0, 4'h0, 1'b1, 1'b0, 4'h5},  // R6 copy
    {1'b0, 4'h0, 1'b1, 1'b1, 4'hA},  // R5
    {1'b0, 4'h0, 1'b1, 1'b1, 4'hF},  // R5
    {1'b0, 4'h0, 1'b1, 1'b1, 4'h4},  // R5 wrap
    {1'b1, 4'h9, 1'b0, 1'b1, 4'h4},  // R7 hold with mode high
    {1'b0, 4'h0, 1'b1, 1'b1, 4'hD},  // R5
    {1'b1, 4'hF, 1'b1, 1'b0, 4'h9},  // R8 old operand copied
    {1'b0, 4'h0, 1'b1, 1'b1, 4'h8},  // R5 wrap
    {1'b0, 4'h0, 1'b0, 1'b0, 4'h8},  // R7
    {1'b0, 4'h0, 1'b1, 1'b0, 4'hF},  // R6
    {1'b0, 4'h0, 1'b1, 1'b1, 4'hE}   // R5 wrap
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    src_we = '0; tsel = '0; opd_we = 1'b0; step = 1'b0; mode_add = 1'b0;
  endtask

  task automatic write_src(input int k, input logic [7:0] d);
    idle();
    src_we[k] = 1'b1; src_wdata = d;
    tick();
    idle();
  endtask

  task automatic xfer(input int k);
    idle();
    tsel[k] = 1'b1;
    tick();
    idle();
  endtask

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    check("R1 dst after reset", dst_q, 8'h00);
    check("R1 acc after reset", {4'h0, acc_q}, 8'h00);
    xfer(2);
    check("R1 cleared source 2", dst_q, 8'h00);

    for (int i = 0; i < 12; i++) begin
      idle();
      opd_we = VEC[i][10]; opd_wdata = VEC[i][9:6];
      step = VEC[i][5]; mode_add = VEC[i][4];
      tick();
      check($sformatf("R5/R6/R7/R8 vector %0d", i), {4'h0, acc_q}, {4'h0, VEC[i][3:0]});
    end
    idle();

    write_src(0, 8'hA1); write_src(1, 8'hB2); write_src(2, 8'hC3); write_src(3, 8'hD4);
    xfer(0); check("R2 line 0", dst_q, 8'hA1);
    xfer(3); check("R2 line 3", dst_q, 8'hD4);
    xfer(1); check("R2 line 1", dst_q, 8'hB2);
    xfer(2); check("R2 line 2", dst_q, 8'hC3);
    tick(); tick();
    check("R3 idle hold", dst_q, 8'hC3);

    write_src(1, 8'h5E);
    xfer(0); check("R4 source 0 untouched", dst_q, 8'hA1);
    xfer(2); check("R4 source 2 untouched", dst_q, 8'hC3);
    xfer(3); check("R4 source 3 untouched", dst_q, 8'hD4);
    xfer(1); check("R4 source 1 written", dst_q, 8'h5E);

    idle();
    src_we[1] = 1'b1; src_wdata = 8'h77; tsel[1] = 1'b1;
    tick();
    idle();
    check("R4 same-cycle transfer gets old", dst_q, 8'h5E);
    xfer(1); check("R4 new content after write", dst_q, 8'h77);

    idle();
    src_we[0] = 1'b1; src_wdata = 8'h11;
    tick();
    idle();
    check("R3 hold while source written", dst_q, 8'h77);

    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 mid-run dst clear", dst_q, 8'h00);
    check("R1 mid-run acc clear", {4'h0, acc_q}, 8'h00);
    xfer(3); check("R1 source 3 cleared", dst_q, 8'h00);
    step = 1'b1; mode_add = 1'b0; tick(); idle();
    check("R1 operand cleared", {4'h0, acc_q}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule